// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous valid/ready host port to an external asynchronous static RAM of 128K bytes. Each accepted request performs one byte read or one byte write. The controller drives the memory address, an active-low and an active-high chip select, an active-low write strobe and an active-low output enable. It handles the shared data bus through separate output, output-enable and input signals, which a pad ring joins into one bidirectional bus.

The memory has no clock, so the controller meets the memory's minimum cycle, pulse, setup and access times by counting system clocks. Each phase length is the nanosecond figure divided by the clock-period parameter and rounded up, with a minimum of one cycle. All nanosecond figures are parameters, so another speed grade or clock rate only needs new parameter values.

Every access starts with one cycle in which the address is presented with all strobes inactive. The write strobe is never asserted together with the output enable. The controller drives the data bus only while the write strobe is already low, and for one cycle after it rises. After each read, a turnaround gap lets the memory release the bus before the controller can drive it.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, the outputs are as follows: chip select low-active high, second chip select low, write strobe high, output enable high, data drive off, req_ready high and rsp_done low.
- R2: A read holds chip select low, output enable low and write strobe high for RD cycles. RD is the largest of ceil(tAA/P), ceil(tACE/P) and ceil(tOE/P), raised if needed so that 1+RD+TURN covers ceil(tRC/P). The byte on mem_dq_in at the last of those cycles is returned on rsp_rdata.
- R3: A write holds chip select low and write strobe low for WP cycles, with output enable high throughout. WP is the largest of ceil(tWP/P), ceil(tAW/P), ceil(tDW/P)+1 and ceil(tWC/P)-2. The byte written is the request's write data.
- R4: The address changes only from one cycle to the next in which chip select and write strobe are both high in both cycles. It stays stable while chip select is low.
- R5: mem_dq_oe is high only from the second cycle of the write pulse through the first cycle after the write strobe rises. This is WP cycles in total, and mem_dq_out carries the write data during them.
- R6: After a read, chip select and output enable stay high for TURN = ceil(tOHZ/P) cycles. No request is accepted during those cycles. The controller never drives the bus while the memory outputs are enabled, nor within TURN cycles after output enable rises.
- R7: req_ready is high only when idle, and a request is taken when req_valid and req_ready are both high at a clock edge. rsp_done is a one-cycle pulse. Counting edges from the accepting edge, it appears after 2+RD edges for a read and after 3+WP edges for a write. req_ready returns after 2+RD+TURN edges for a read and together with rsp_done for a write.
- R8: mem_ce2 is always the complement of mem_ce_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data received from the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The bench builds the controller with a 5-bit address and an 8 ns clock period, keeping the 55 ns timing figures. This gives read, write and turnaround phases of 7, 7 and 3 cycles. The small address space allows every location to be written and read back. It also allows a read immediately followed by a write to be run at every address, so each turnaround gap is seen adjacent to a drive window. The bench derives all phase lengths from the nanosecond values with its own ceiling arithmetic. A behavioural memory model flags bus contention, strobe overlap and any address change made while the strobes are active.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSET,
      ST_RACC,
      ST_RTURN,
      ST_WSET,
      ST_WPUL,
      ST_WHOLD
   } sram_ctl_state_e;

   // clocks needed to cover a nanosecond figure, never less than one
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      int unsigned r;
      r = (per == 0) ? 1 : (ns + per - 1) / per;
      if (r < 1) r = 1;
      return r;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_phase_cnt.sv
module sram_ctl_phase_cnt #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC   = 7,
   parameter int unsigned WP_CYC   = 7,
   parameter int unsigned TURN_CYC = 3,
   parameter int unsigned CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_fire,
   input  logic             req_write,
   input  logic             cnt_zero,
   output sram_ctl_state_e  state_q,
   output sram_ctl_state_e  state_nxt,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output logic             sample_en,
   output logic             done_set
);

   always_comb begin
      state_nxt = state_q;
      cnt_load  = 1'b0;
      cnt_val   = '0;
      sample_en = 1'b0;
      done_set  = 1'b0;
      unique case (state_q)
         ST_IDLE:
            if (req_fire) state_nxt = req_write ? ST_WSET : ST_RSET;
         ST_RSET: begin
            state_nxt = ST_RACC;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(RD_CYC - 1);
         end
         ST_RACC:
            if (cnt_zero) begin
               state_nxt = ST_RTURN;
               cnt_load  = 1'b1;
               cnt_val   = CNT_W'(TURN_CYC - 1);
               sample_en = 1'b1;
               done_set  = 1'b1;
            end
         ST_RTURN:
            if (cnt_zero) state_nxt = ST_IDLE;
         ST_WSET: begin
            state_nxt = ST_WPUL;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(WP_CYC - 1);
         end
         ST_WPUL:
            if (cnt_zero) state_nxt = ST_WHOLD;
         ST_WHOLD: begin
            state_nxt = ST_IDLE;
            done_set  = 1'b1;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_nxt;
   end

   // R6
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RTURN) |-> !req_fire);

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
   import sram_ctl_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  sram_ctl_state_e state_q,
   input  sram_ctl_state_e state_nxt,
   output logic            mem_ce_n,
   output logic            mem_ce2,
   output logic            mem_we_n,
   output logic            mem_oe_n,
   output logic            mem_dq_oe
);

   logic sel_nxt, wr_nxt, rd_nxt, drv_nxt;

   always_comb begin
      rd_nxt  = (state_nxt == ST_RACC);
      wr_nxt  = (state_nxt == ST_WPUL);
      sel_nxt = rd_nxt | wr_nxt;
      // drive starts one cycle into the pulse and covers the hold cycle
      drv_nxt = (wr_nxt && state_q == ST_WPUL) || (state_nxt == ST_WHOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_ce2   <= 1'b0;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_ce_n  <= !sel_nxt;
         mem_ce2   <= sel_nxt;
         mem_we_n  <= !wr_nxt;
         mem_oe_n  <= !rd_nxt;
         mem_dq_oe <= drv_nxt;
      end
   end

   // R8
   ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce2 == !mem_ce_n);

   // R3
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   // R5
   drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !$past(mem_we_n));

   // R6
   no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 8,
   parameter int unsigned T_RC_NS       = 55,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_ACE_NS      = 55,
   parameter int unsigned T_OE_NS       = 30,
   parameter int unsigned T_OHZ_NS      = 20,
   parameter int unsigned T_WC_NS       = 55,
   parameter int unsigned T_AW_NS       = 50,
   parameter int unsigned T_WP_NS       = 45,
   parameter int unsigned T_DW_NS       = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_ce_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n
);

   localparam int unsigned P        = CLK_PERIOD_NS;
   localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, P);
   localparam int unsigned RD_BASE  = umax(umax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_ACE_NS, P)),
                                           ns_to_cyc(T_OE_NS, P));
   localparam int unsigned RC_CYC   = ns_to_cyc(T_RC_NS, P);
   localparam int unsigned RD_CYC   = (RC_CYC > 1 + TURN_CYC + RD_BASE) ? RC_CYC - 1 - TURN_CYC : RD_BASE;
   localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, P);
   localparam int unsigned WP_CYC   = umax(umax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_AW_NS, P)),
                                           umax(ns_to_cyc(T_DW_NS, P) + 1, (WC_CYC > 2) ? WC_CYC - 2 : 1));
   localparam int unsigned MAX_CYC  = umax(RD_CYC, umax(WP_CYC, TURN_CYC));
   localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("sram_ctl: CLK_PERIOD_NS must be non-zero");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("sram_ctl: ADDR_W and DATA_W must be non-zero");
      end
      if (WP_CYC < 2) begin : g_bad_pulse
         $error("sram_ctl: write pulse must span at least two cycles");
      end
   endgenerate

   sram_ctl_state_e  state_q, state_nxt;
   logic             req_fire, cnt_load, cnt_zero, sample_en, done_set;
   logic [CNT_W-1:0] cnt_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              done_q;

   assign req_ready = (state_q == ST_IDLE);
   assign req_fire  = req_valid && req_ready;

   sram_ctl_seq #(
      .RD_CYC  (RD_CYC),
      .WP_CYC  (WP_CYC),
      .TURN_CYC(TURN_CYC),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .req_write(req_write),
      .cnt_zero (cnt_zero),
      .state_q  (state_q),
      .state_nxt(state_nxt),
      .cnt_load (cnt_load),
      .cnt_val  (cnt_val),
      .sample_en(sample_en),
      .done_set (done_set)
   );

   sram_ctl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load),
      .load_val(cnt_val),
      .zero    (cnt_zero)
   );

   sram_ctl_pins u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (state_q),
      .state_nxt(state_nxt),
      .mem_ce_n (mem_ce_n),
      .mem_ce2  (mem_ce2),
      .mem_we_n (mem_we_n),
      .mem_oe_n (mem_oe_n),
      .mem_dq_oe(mem_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (sample_en) rdata_q <= mem_dq_in;
         done_q <= done_set;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign rsp_rdata  = rdata_q;
   assign rsp_done   = done_q;

   // write strobe low-run length, for the pulse-width check
   logic [CNT_W:0] we_low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_low_run <= '0;
      else if (!mem_we_n) we_low_run <= we_low_run + 1'b1;
      else                we_low_run <= '0;
   end

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> $stable(mem_addr));

   // R3
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_run == (CNT_W+1)'(WP_CYC)));

   // R6
   turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |=> !mem_dq_oe);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

   localparam int AW  = 5;
   localparam int DW  = 8;
   localparam int PER = 8;

   function automatic int cd(input int ns);
      int r;
      r = (ns + PER - 1) / PER;
      return (r < 1) ? 1 : r;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int TURN_E = 3;   // ceil(20/8)
   localparam int RD_E   = 7;   // max(ceil(55/8), ceil(30/8)); 1+7+3 >= ceil(55/8)
   localparam int WP_E   = 7;   // max(ceil(45/8), ceil(50/8), ceil(25/8)+1, ceil(55/8)-2)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_done;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic          mem_dq_oe, mem_ce_n, mem_ce2, mem_we_n, mem_oe_n;

   always #4 clk = ~clk;

   sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) u_sram_ctl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   // behavioural memory
   logic [DW-1:0] mem [2**AW];
   logic          model_drv;
   assign model_drv = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
   assign mem_dq_in = model_drv ? mem[mem_addr] : '0;
   always @(posedge clk)
      if (!mem_ce_n && mem_ce2 && !mem_we_n && mem_dq_oe) mem[mem_addr] <= mem_dq_out;

   int checks = 0, fails = 0;
   bit finished = 0;
   logic [DW-1:0] cur_wdata = '0;

   // pin monitor
   int we_run = 0, oe_run = 0, drv_run = 0;
   int last_we = 0, last_oe = 0, last_drv = 0, since_oe = 100;
   int addr_bad = 0, ce2_bad = 0, wroe_bad = 0, drv_bad = 0, val_bad = 0, turn_bad = 0, cont_bad = 0;
   logic p_ce = 1, p_we = 1, p_oe = 1, p_drv = 0;
   logic [AW-1:0] p_addr = '0;

   always @(negedge clk) if (rst_n) begin
      if (!mem_we_n) we_run++; else if (!p_we) begin last_we = we_run; we_run = 0; end
      if (!mem_oe_n) oe_run++; else if (!p_oe) begin last_oe = oe_run; oe_run = 0; end
      if (mem_dq_oe) drv_run++; else if (p_drv) begin last_drv = drv_run; drv_run = 0; end
      if (mem_addr != p_addr && (!mem_ce_n || !mem_we_n || !p_ce || !p_we)) addr_bad++;
      if (mem_ce2 == mem_ce_n) ce2_bad++;
      if (!mem_we_n && !mem_oe_n) wroe_bad++;
      if (mem_dq_oe && p_we) drv_bad++;
      if (mem_dq_oe && mem_dq_out != cur_wdata) val_bad++;
      if (mem_dq_oe && since_oe < TURN_E) turn_bad++;
      if (mem_dq_oe && model_drv) cont_bad++;
      if (!mem_oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
      p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_drv = mem_dq_oe; p_addr = mem_addr;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input int a, input int d, output int rd,
                        output int lat, output int rdy);
      int cnt;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
      if (wr) cur_wdata = DW'(d);
      @(negedge clk);
      req_valid = 1'b0;
      cnt = 1;
      chk(!req_ready, "R7 ready low when busy", req_ready, 0);
      while (!rsp_done && cnt < 60) begin @(negedge clk); cnt++; end
      lat = cnt; rd = rsp_rdata;
      rdy = req_ready ? lat : 0;
      @(negedge clk); cnt++;
      chk(!rsp_done, "R7 done one cycle", rsp_done, 0);
      while (!req_ready && cnt < 80) begin @(negedge clk); cnt++; end
      if (rdy == 0) rdy = cnt;
   endtask

   function automatic int pat(input int a, input int k);
      return ((a * 29 + 91 + k * 113) ^ (a << 3)) & 255;
   endfunction

   initial begin
      int rd, lat, rdy;
      chk(TURN_E == cd(20) && RD_E == mx(cd(55), cd(30)) &&
          WP_E == mx(mx(cd(45), cd(50)), mx(cd(25) + 1, cd(55) - 2)), "R2 R3 derived lengths", WP_E, cd(50));
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
          {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_done, "R1 handshake after reset", {req_ready, rsp_done}, 2'b10);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes after reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

      for (int a = 0; a < 2**AW; a++) begin
         do_op(1'b1, a, pat(a, 0), rd, lat, rdy);
         chk(lat == 3 + WP_E, "R7 write done latency", lat, 3 + WP_E);
         chk(rdy == lat, "R7 write ready with done", rdy, lat);
         chk(last_we == WP_E, "R3 write pulse cycles", last_we, WP_E);
         chk(last_drv == WP_E, "R5 drive window cycles", last_drv, WP_E);
      end
      for (int a = 0; a < 2**AW; a++) begin
         do_op(1'b0, a, 0, rd, lat, rdy);
         chk(rd == pat(a, 0), "R2 read data", rd, pat(a, 0));
         chk(lat == 2 + RD_E, "R7 read done latency", lat, 2 + RD_E);
         chk(rdy == 2 + RD_E + TURN_E, "R6 read turnaround", rdy, 2 + RD_E + TURN_E);
         chk(last_oe == RD_E, "R2 read strobe cycles", last_oe, RD_E);
      end
      // read immediately followed by write at every address, then read back
      for (int a = 0; a < 2**AW; a++) begin
         do_op(1'b0, (a + 7) % (2**AW), 0, rd, lat, rdy);
         do_op(1'b1, a, pat(a, 1), rd, lat, rdy);
         do_op(1'b0, a, 0, rd, lat, rdy);
         chk(rd == pat(a, 1), "R3 rewrite then read", rd, pat(a, 1));
      end
      repeat (4) @(negedge clk);
      chk(addr_bad == 0, "R4 address moved with strobe active", addr_bad, 0);
      chk(ce2_bad == 0, "R8 ce2 complement", ce2_bad, 0);
      chk(wroe_bad == 0, "R3 oe low during write", wroe_bad, 0);
      chk(drv_bad == 0, "R5 drive before write strobe", drv_bad, 0);
      chk(val_bad == 0, "R5 drive value", val_bad, 0);
      chk(turn_bad == 0, "R6 drive inside turnaround", turn_bad, 0);
      chk(cont_bad == 0, "R6 bus contention", cont_bad, 0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule